// File: doc/BRIEF.md
# Dual-Port Receive I/Q Deinterleaver

This block sits behind the parallel receive interface of a radio transceiver. Two 12-bit ports are sampled on both edges of the data clock, so each clock period holds two word slots. Port 0 always carries the in-phase word of a slot and port 1 always carries the quadrature word of the same slot. The block turns the stream of slots into tagged I/Q pairs. A static configuration input selects one or two receive channels.

With one channel, every slot belongs to channel 1. Each clock period then yields two consecutive pairs: lane A holds the rising-edge slot and lane B holds the falling-edge slot. With two channels, the slots alternate between channel 1 and channel 2, and a frame strobe is high during each channel 1 slot. The block locks to the strobe and pairs each channel 1 slot with the channel 2 slot that follows it. It then presents both pairs together under a single valid pulse: channel 1 on lane A and channel 2 on lane B. A pair may straddle two clock periods. A sticky flag reports a frame strobe that goes missing where the block expects channel 1.

Top module: `iqd_rx_deinterleave`

## Requirements
- R1: Every word is carried unchanged as a 12-bit two's complement value, bit 11 being the sign. The port 0 word of a slot appears on a lane's I output and the port 1 word appears on the same lane's Q output. This holds for the extremes 0x7FF and 0x800.
- R2: Both clock edges capture a slot. Of the two slots in one clock period, the rising-edge slot comes first.
- R3: With `dual_rx` low, `rx_valid` is high once per clock period for every period after reset. Lane A carries the rising-edge slot and lane B the falling-edge slot, and both channel tags are 0 (channel 1). The result for the slots sampled in period k is presented after rising edge k+1.
- R4: With `dual_rx` low, `rx_frame` has no effect on the data or the tags, and `align_err` stays 0.
- R5: With `dual_rx` high, a slot with `rx_frame` high is channel 1. The tag then alternates channel 2, channel 1, and so on, slot by slot.
- R6: With `dual_rx` high, a channel 2 slot that follows a held channel 1 slot produces one `rx_valid` cycle. Lane A then carries the channel 1 pair with tag 0 and lane B the channel 2 pair with tag 1. This includes pairs that straddle two periods. It appears after the rising edge that follows the period of the channel 2 slot, and `rx_valid` is low in all other cycles.
- R7: With `dual_rx` high, slots before the first `rx_frame` high are discarded: no `rx_valid` and no error.
- R8: Once locked in two-channel mode, a slot that is expected to be channel 1 but arrives with `rx_frame` low sets `align_err`, and the slot is still used as channel 1. The flag stays high until reset.
- R9: An `rx_frame` high on a slot expected to be channel 2 realigns the block. That slot becomes channel 1 and replaces any held channel 1 pair, and `align_err` is not set.
- R10: While `rst_n` is low, `rx_valid` and `align_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock; both edges carry a slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_rx | input | 1 | 1 selects two receive channels, 0 selects one; held static between resets |
| rx_frame | input | 1 | Frame strobe, high during channel 1 slots |
| port0_word | input | 12 | In-phase word of the current slot |
| port1_word | input | 12 | Quadrature word of the current slot |
| rx_valid | output | 1 | Both lanes hold a new result |
| lane_a_chan | output | 1 | Channel tag of lane A (0 = channel 1, 1 = channel 2) |
| lane_a_i | output | 12 | Lane A in-phase sample |
| lane_a_q | output | 12 | Lane A quadrature sample |
| lane_b_chan | output | 1 | Channel tag of lane B |
| lane_b_i | output | 12 | Lane B in-phase sample |
| lane_b_q | output | 12 | Lane B quadrature sample |
| align_err | output | 1 | Sticky frame alignment error |

## Verification
Every result of the block, whether output pairs, the valid pulse or the error flag, is due one rising edge after the clock period in which its last slot was sampled. The bench drives the rising-edge slot shortly after the falling edge and the falling-edge slot shortly after the rising edge. It compares outputs 1 ns after each rising edge against an expectation that its own slot model filed for the previous period. A trailing flush edge collects the last result before each reset. In this way straddling pairs, realignment and the error flag are each checked in exactly the cycle they are due.

// File: rtl/iqd_pkg.sv
package iqd_pkg;

    // Width of one port word
    localparam int SAMPLE_W = 12;
    // Slots captured per clock period (rising and falling edge)
    localparam int LANES = 2;

    typedef logic signed [SAMPLE_W-1:0] smp_t;

    // One captured slot: strobe level plus both port words
    typedef struct packed {
        logic frm;
        smp_t i;
        smp_t q;
    } slot_t;

    // One slot after channel tagging
    typedef struct packed {
        logic vld;
        logic chan;   // 0 = channel 1, 1 = channel 2
        smp_t i;
        smp_t q;
    } tag_t;

endpackage

// File: rtl/iqd_ddr_capture.sv
module iqd_ddr_capture
    import iqd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_i,
    input  logic [SAMPLE_W-1:0]    p0_i,
    input  logic [SAMPLE_W-1:0]    p1_i,
    output logic                   cap_vld_o,
    output slot_t [LANES-1:0]      slots_o
);

    typedef struct packed {
        logic  vld;
        slot_t rise;
    } cap_st_t;

    cap_st_t cap_d, cap_q;
    slot_t   fall_d, fall_q;
    slot_t   pin_slot;

    always_comb begin
        pin_slot.frm = frame_i;
        pin_slot.i   = smp_t'(p0_i);
        pin_slot.q   = smp_t'(p1_i);

        cap_d      = cap_q;
        cap_d.vld  = 1'b1;
        cap_d.rise = pin_slot;
        fall_d     = pin_slot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= fall_d;
    end

    // Lane 0 is the earlier (rising-edge) slot of the period
    always_comb begin
        slots_o    = '0;
        slots_o[0] = cap_q.rise;
        slots_o[1] = fall_q;
    end

    assign cap_vld_o = cap_q.vld;

    assert_capture_stays_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.vld |=> cap_q.vld);

endmodule

// File: rtl/iqd_slot_tagger.sv
module iqd_slot_tagger
    import iqd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dual_i,
    input  logic                   cap_vld_i,
    input  slot_t [LANES-1:0]      slots_i,
    output tag_t  [LANES-1:0]      tags_o,
    output logic                   err_o
);

    typedef struct packed {
        logic locked;
        logic exp_ch2;
        logic err;
    } tg_st_t;

    tg_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tags_o = '0;
        for (int n = 0; n < LANES; n++) begin
            tags_o[n].i = slots_i[n].i;
            tags_o[n].q = slots_i[n].q;
            if (cap_vld_i) begin
                if (!dual_i) begin
                    tags_o[n].vld  = 1'b1;
                    tags_o[n].chan = 1'b0;
                end else if (slots_i[n].frm) begin
                    tags_o[n].vld  = 1'b1;
                    tags_o[n].chan = 1'b0;
                    st_d.locked    = 1'b1;
                    st_d.exp_ch2   = 1'b1;
                end else if (st_d.locked) begin
                    tags_o[n].vld  = 1'b1;
                    tags_o[n].chan = st_d.exp_ch2;
                    if (!st_d.exp_ch2) begin
                        st_d.err = 1'b1;
                    end
                    st_d.exp_ch2 = !st_d.exp_ch2;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_o = st_q.err;

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);

    assert_single_no_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_i && !st_q.err) |=> !st_q.err);

    for (genvar n = 1; n < LANES; n++) begin : g_seq_chk
        assert_ch2_follows_ch1_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (dual_i && tags_o[n-1].vld && !tags_o[n-1].chan && !slots_i[n].frm)
            |-> (tags_o[n].vld && tags_o[n].chan));
    end

endmodule

// File: rtl/iqd_pair_builder.sv
module iqd_pair_builder
    import iqd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dual_i,
    input  tag_t  [LANES-1:0]      tags_i,
    output logic                   valid_o,
    output tag_t                   lane_a_o,
    output tag_t                   lane_b_o
);

    typedef struct packed {
        logic hold_v;
        smp_t hold_i;
        smp_t hold_q;
        logic out_v;
        tag_t a;
        tag_t b;
    } pb_st_t;

    pb_st_t st_d, st_q;
    logic   any_ch2;

    always_comb begin
        st_d       = st_q;
        st_d.out_v = 1'b0;
        if (!dual_i) begin
            st_d.hold_v = 1'b0;
            if (tags_i[0].vld && tags_i[1].vld) begin
                st_d.out_v = 1'b1;
                st_d.a     = tags_i[0];
                st_d.b     = tags_i[1];
            end
        end else begin
            for (int n = 0; n < LANES; n++) begin
                if (tags_i[n].vld) begin
                    if (!tags_i[n].chan) begin
                        st_d.hold_v = 1'b1;
                        st_d.hold_i = tags_i[n].i;
                        st_d.hold_q = tags_i[n].q;
                    end else if (st_d.hold_v) begin
                        st_d.out_v  = 1'b1;
                        st_d.a.vld  = 1'b1;
                        st_d.a.chan = 1'b0;
                        st_d.a.i    = st_d.hold_i;
                        st_d.a.q    = st_d.hold_q;
                        st_d.b      = tags_i[n];
                        st_d.hold_v = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o  = st_q.out_v;
    assign lane_a_o = st_q.a;
    assign lane_b_o = st_q.b;

    always_comb begin
        any_ch2 = 1'b0;
        for (int n = 0; n < LANES; n++) begin
            if (tags_i[n].vld && tags_i[n].chan) any_ch2 = 1'b1;
        end
    end

    assert_single_stream_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_i && tags_i[0].vld) |=> st_q.out_v);

    assert_group_needs_ch2_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_i && !any_ch2) |=> !st_q.out_v);

endmodule

// File: rtl/iqd_rx_deinterleave.sv
module iqd_rx_deinterleave
    import iqd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dual_rx,
    input  logic                   rx_frame,
    input  logic [SAMPLE_W-1:0]    port0_word,
    input  logic [SAMPLE_W-1:0]    port1_word,
    output logic                   rx_valid,
    output logic                   lane_a_chan,
    output logic [SAMPLE_W-1:0]    lane_a_i,
    output logic [SAMPLE_W-1:0]    lane_a_q,
    output logic                   lane_b_chan,
    output logic [SAMPLE_W-1:0]    lane_b_i,
    output logic [SAMPLE_W-1:0]    lane_b_q,
    output logic                   align_err
);

    logic               cap_vld;
    slot_t [LANES-1:0]  slots;
    tag_t  [LANES-1:0]  tags;
    tag_t               lane_a;
    tag_t               lane_b;

    iqd_ddr_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_i   (rx_frame),
        .p0_i      (port0_word),
        .p1_i      (port1_word),
        .cap_vld_o (cap_vld),
        .slots_o   (slots)
    );

    iqd_slot_tagger u_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .dual_i    (dual_rx),
        .cap_vld_i (cap_vld),
        .slots_i   (slots),
        .tags_o    (tags),
        .err_o     (align_err)
    );

    iqd_pair_builder u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .dual_i    (dual_rx),
        .tags_i    (tags),
        .valid_o   (rx_valid),
        .lane_a_o  (lane_a),
        .lane_b_o  (lane_b)
    );

    assign lane_a_chan = lane_a.chan;
    assign lane_a_i    = lane_a.i;
    assign lane_a_q    = lane_a.q;
    assign lane_b_chan = lane_b.chan;
    assign lane_b_i    = lane_b.i;
    assign lane_b_q    = lane_b.q;

    assert_err_only_dual_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_rx && !align_err) |=> !align_err);

endmodule

// File: tb/tb_iqd_rx_deinterleave.sv
module tb_iqd_rx_deinterleave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dual_rx = 1'b0;
    logic        rx_frame = 1'b0;
    logic [11:0] port0_word = '0;
    logic [11:0] port1_word = '0;
    logic        rx_valid, lane_a_chan, lane_b_chan, align_err;
    logic [11:0] lane_a_i, lane_a_q, lane_b_i, lane_b_q;

    always #5 clk = ~clk;

    iqd_rx_deinterleave dut (
        .clk(clk), .rst_n(rst_n), .dual_rx(dual_rx), .rx_frame(rx_frame),
        .port0_word(port0_word), .port1_word(port1_word),
        .rx_valid(rx_valid), .lane_a_chan(lane_a_chan), .lane_a_i(lane_a_i),
        .lane_a_q(lane_a_q), .lane_b_chan(lane_b_chan), .lane_b_i(lane_b_i),
        .lane_b_q(lane_b_q), .align_err(align_err)
    );

    int checks = 0;
    int failures = 0;
    string req_v = "R10";
    string req_d = "R1";
    string req_e = "R10";

    // reference slot model
    logic        m_dual, m_lock, m_exp, m_hold_v, m_err;
    logic [24:0] m_hold;
    logic        p_v, p_err;
    logic [24:0] p_a, p_b;

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_pending();
        chk(rx_valid == p_v, req_v, 64'(rx_valid), 64'(p_v));
        if (p_v) begin
            chk({lane_a_chan, lane_a_i, lane_a_q, lane_b_chan, lane_b_i, lane_b_q} == {p_a, p_b},
                req_d, 64'({lane_a_chan, lane_a_i, lane_a_q, lane_b_chan, lane_b_i, lane_b_q}),
                64'({p_a, p_b}));
        end
        chk(align_err == p_err, req_e, 64'(align_err), 64'(p_err));
    endtask

    task automatic model_slot(input logic f, input logic [11:0] i, input logic [11:0] q);
        logic ch;
        logic ok;
        ch = 1'b0;
        ok = 1'b0;
        if (f) begin
            ok = 1'b1; m_lock = 1'b1;
        end else if (m_lock) begin
            ok = 1'b1; ch = m_exp;
            if (!ch) m_err = 1'b1;
        end
        if (ok) begin
            m_exp = !ch;
            if (!ch) begin
                m_hold_v = 1'b1; m_hold = {1'b0, i, q};
            end else if (m_hold_v) begin
                p_v = 1'b1; p_a = m_hold; p_b = {1'b1, i, q}; m_hold_v = 1'b0;
            end
        end
    endtask

    task automatic drive(input logic f0, input logic [11:0] i0, input logic [11:0] q0,
                         input logic f1, input logic [11:0] i1, input logic [11:0] q1);
        @(negedge clk); #2;
        rx_frame = f0; port0_word = i0; port1_word = q0;
        @(posedge clk); #1;
        check_pending();
        #1;
        rx_frame = f1; port0_word = i1; port1_word = q1;
        p_v = 1'b0;
        if (!m_dual) begin
            p_v = 1'b1; p_a = {1'b0, i0, q0}; p_b = {1'b0, i1, q1};
        end else begin
            model_slot(f0, i0, q0);
            model_slot(f1, i1, q1);
        end
        p_err = m_err;
    endtask

    task automatic flush();
        @(posedge clk); #1;
        check_pending();
    endtask

    task automatic do_reset(input logic dual);
        @(posedge clk); #2;
        rst_n = 1'b0;
        dual_rx = dual;
        rx_frame = 1'b0; port0_word = '0; port1_word = '0;
        m_dual = dual; m_lock = 0; m_exp = 0; m_hold_v = 0; m_err = 0; m_hold = '0;
        p_v = 0; p_err = 0; p_a = '0; p_b = '0;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        chk(rx_valid == 1'b0, "R10", 64'(rx_valid), 64'd0);
        chk(align_err == 1'b0, "R10", 64'(align_err), 64'd0);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        checks++;
        failures++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // single channel: R1 R2 R3 R4 over a value sweep with toggling strobe
        do_reset(1'b0);
        req_v = "R3"; req_d = "R1_R2"; req_e = "R4";
        for (int k = 0; k < 48; k++) begin
            logic [11:0] a0, b0, a1, b1;
            a0 = (k == 0) ? 12'h7FF : 12'(k * 83 + 17);
            b0 = (k == 0) ? 12'h800 : 12'(k * 151 + 3);
            a1 = (k == 1) ? 12'h800 : 12'(k * 29 + 1000);
            b1 = (k == 1) ? 12'h7FF : ~a0;
            drive(k[0], a0, b0, k[1], a1, b1);
        end
        flush();

        // two channels: R7 before lock, then R5 R6 with groups inside one period
        do_reset(1'b1);
        req_v = "R7"; req_d = "R7"; req_e = "R7";
        for (int k = 0; k < 4; k++) drive(1'b0, 12'(k + 5), 12'(k + 9), 1'b0, 12'(k + 20), 12'(k + 40));
        req_v = "R6"; req_d = "R5_R6"; req_e = "R8";
        for (int k = 0; k < 24; k++) begin
            logic [11:0] a0, b0;
            a0 = (k == 3) ? 12'h7FF : 12'(k * 211 + 7);
            b0 = (k == 3) ? 12'h800 : 12'(k * 97 + 300);
            drive(1'b1, a0, b0, 1'b0, ~b0, 12'(a0 + 12'd1));
        end
        // strobe moves to the falling slot: R8 error, groups straddle periods (R6)
        req_e = "R8";
        for (int k = 0; k < 8; k++) drive(1'b0, 12'(k * 13 + 1), 12'(k * 17 + 2), 1'b1, 12'(k * 19 + 3), 12'(k * 23 + 4));
        flush();

        // two channels, straddling from the start, then realignment R9
        do_reset(1'b1);
        req_v = "R6"; req_d = "R6"; req_e = "R9";
        for (int k = 0; k < 10; k++) drive(1'b0, 12'(k * 41 + 600), 12'(k * 43 + 700), 1'b1, 12'(k * 47 + 800), 12'(k * 53 + 900));
        req_v = "R9"; req_d = "R9"; req_e = "R9";
        drive(1'b1, 12'h0AA, 12'h055, 1'b0, 12'h0F0, 12'h00F);
        for (int k = 0; k < 10; k++) drive(1'b1, 12'(k * 59 + 111), 12'(k * 61 + 222), 1'b0, 12'(k * 67 + 333), 12'(k * 71 + 444));
        // double strobe: second one lands on an expected channel 2 slot
        drive(1'b1, 12'h123, 12'h456, 1'b1, 12'h789, 12'hABC);
        drive(1'b0, 12'h321, 12'h654, 1'b1, 12'h987, 12'hCBA);
        drive(1'b0, 12'h111, 12'h222, 1'b1, 12'h333, 12'h444);
        flush();

        do_reset(1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule